// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block sits beside the access sequencer of a 256K x 1 dynamic RAM. Once reset is released it waits out the power-up settling pause. It then runs a short train of wake-up RAS cycles, after which it raises `init_done_o`. From then on it keeps the array alive with RAS-only refresh cycles. An interval timer produces refresh slots at an even rate, so that every row is visited inside one refresh period. CAS is never driven low by this block.

The block does not drive the memory pins on its own. It raises `req_o` when it needs the bus. A cycle starts only on a clock edge where the access sequencer holds `gnt_i` high. From that edge until precharge completes, `busy_o` stays high so the sequencer keeps off RAS and the address pins. Refresh slots that pass while the grant is withheld are counted, up to a limit. They are then issued back to back once the grant returns.

If the memory sees no RAS cycle for a full refresh period after initialization, `init_done_o` drops and the wake-up train runs again. Every time figure is given in nanoseconds and converted to clock cycles from the clock-period parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted: `ras_n_o`=1, `cas_n_o`=1, `req_o`=0, `busy_o`=0, `init_done_o`=0, `row_o`=0.
- R2: For the first ceil(PAUSE_NS/CLK_NS) clock edges after reset release, `req_o` stays 0 and `ras_n_o` stays 1. `req_o` first rises right after edge number ceil(PAUSE_NS/CLK_NS).
- R3: `init_done_o` rises at the clock edge on which the precharge of the WAKE_CYCLES-th wake-up RAS cycle (default 8) ends, and never earlier.
- R4: Every RAS low pulse lasts exactly ceil((RAS_LOW_NS+MARGIN_NS)/CLK_NS) cycles (at least 150 ns). Between pulses, RAS stays high for at least ceil((RAS_PRE_NS+MARGIN_NS)/CLK_NS) cycles (at least 100 ns); back-to-back pulses are separated by that count plus one.
- R5: `cas_n_o` is 1 at all times.
- R6: `row_o` holds still while RAS is low. It advances by one when each RAS cycle completes, wrapping from 2^ROW_W-1 to 0. Each RAS cycle therefore presents the previous row plus one.
- R7: RAS falls only on a clock edge at which both `req_o` and `gnt_i` are 1. `busy_o` is 1 whenever RAS is low and through the following precharge. `req_o` is 0 while `busy_o` is 1.
- R8: After `init_done_o`, a refresh slot comes every (REF_PERIOD_NS/2^ROW_W − INT_MARGIN_NS)/CLK_NS cycles. With the grant always given and no backlog, RAS falls are exactly that far apart. Every row is refreshed within any REF_PERIOD_NS window.
- R9: Refresh slots missed while the grant is withheld are held as a backlog of at most PEND_MAX. Once the grant returns, the backlog is issued back to back.
- R10: If no RAS cycle starts for REF_PERIOD_NS/CLK_NS cycles after `init_done_o`, `init_done_o` falls exactly that many cycles after the last RAS fall. The backlog is dropped and WAKE_CYCLES wake-up cycles run again before `init_done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Request for the RAS and address bus |
| busy_o | output | 1 | A RAS cycle owned by this block is in progress |
| init_done_o | output | 1 | Power-up pause and wake-up cycles complete |
| ras_n_o | output | 1 | Row address strobe, active low |
| cas_n_o | output | 1 | Column address strobe, held inactive |
| row_o | output | ROW_W | Row address driven while RAS is low |

## Verification
A wrong row counter shows at the very next RAS fall as a row other than the previous one plus one. A broken pulse timer shows at the end of that pulse, as a low or high run of the wrong length. A miscounted pause or wake-up count moves the first request or the rise of `init_done_o` by a measurable number of edges. Lost backlog or a stale idle counter show within one refresh slot: either the tight spacing fails to appear once the grant returns, or `init_done_o` falls on a cycle other than one refresh period after the last fall.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } sched_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_PRE  = 2'd2
  } ras_phase_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/ras_pulse_gen.sv
module ras_pulse_gen
  import dram_ref_pkg::*;
#(
  parameter int unsigned LOW_CYC = 38,
  parameter int unsigned PRE_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned MAXC = (LOW_CYC > PRE_CYC) ? LOW_CYC : PRE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  ras_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          ras_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_LOW;
          cnt_q   <= CW'(LOW_CYC - 1);
          ras_n_q <= 1'b0;
        end
        PH_LOW: if (cnt_q == '0) begin
          phase_q <= PH_PRE;
          cnt_q   <= CW'(PRE_CYC - 1);
          ras_n_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_PRE: if (cnt_q == '0) phase_q <= PH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ras_n_o  = ras_n_q;
  assign active_o = (phase_q != PH_IDLE);
  assign done_o   = (phase_q == PH_PRE) && (cnt_q == '0);

  // checker counters: run lengths of RAS low and high
  logic [CW-1:0] chk_low_q, chk_high_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_low_q  <= '0;
      chk_high_q <= '0;
    end else begin
      chk_low_q  <= ras_n_q ? '0 : chk_low_q + 1'b1;
      if (!ras_n_q)                       chk_high_q <= '0;
      else if (chk_high_q != CW'(PRE_CYC)) chk_high_q <= chk_high_q + 1'b1;
    end
  end

  assert_low_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_q) |-> chk_low_q == CW'(LOW_CYC));
  assert_pre_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_q) |-> $past(chk_high_q) == CW'(PRE_CYC));

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INT_CYC = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(INT_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(INT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ref_backlog_ctr.sv
module ref_backlog_ctr #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic pending_o
);
  localparam int unsigned CW = $clog2(PEND_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CW'(PEND_MAX)) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign pending_o = (cnt_q != '0);

  assert_pend_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PEND_MAX));
  assert_pend_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i) |-> cnt_q != '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_NS        = 4,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned REF_PERIOD_NS = 4000000,
  parameter int unsigned ROW_W         = 8,
  parameter int unsigned WAKE_CYCLES   = 8,
  parameter int unsigned RAS_LOW_NS    = 150,
  parameter int unsigned RAS_PRE_NS    = 100,
  parameter int unsigned MARGIN_NS     = 0,
  parameter int unsigned INT_MARGIN_NS = 625,
  parameter int unsigned PEND_MAX      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             init_done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned ROWS      = 1 << ROW_W;
  localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_NS);
  localparam int unsigned LOW_CYC   = ns_to_cyc(RAS_LOW_NS + MARGIN_NS, CLK_NS);
  localparam int unsigned PRE_CYC   = ns_to_cyc(RAS_PRE_NS + MARGIN_NS, CLK_NS);
  localparam int unsigned INT_CYC   = (REF_PERIOD_NS / ROWS - INT_MARGIN_NS) / CLK_NS;
  localparam int unsigned IDLE_CYC  = REF_PERIOD_NS / CLK_NS;
  localparam int unsigned PAUSE_W   = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WAKE_W    = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned IDLE_W    = $clog2(IDLE_CYC + 1);

  sched_state_e      state_q;
  logic [PAUSE_W-1:0] pause_q;
  logic [WAKE_W-1:0]  wake_q;
  logic [IDLE_W-1:0]  idle_q;
  logic               init_q;
  logic [ROW_W-1:0]   row_q;

  logic active, pulse_done, pend_nz, tick;
  logic want, req, start, idle_hit, ras_n;

  assign want     = (state_q == ST_WAKE) || ((state_q == ST_RUN) && pend_nz);
  assign req      = want && !active;
  assign start    = req && gnt_i;
  assign idle_hit = (state_q == ST_RUN) && !start && (idle_q == IDLE_W'(IDLE_CYC - 1));

  ras_pulse_gen #(.LOW_CYC(LOW_CYC), .PRE_CYC(PRE_CYC)) u_pulse (
    .clk_i, .rst_ni, .start_i(start),
    .ras_n_o(ras_n), .active_o(active), .done_o(pulse_done)
  );

  ref_interval_timer #(.INT_CYC(INT_CYC)) u_timer (
    .clk_i, .rst_ni, .en_i(state_q == ST_RUN), .tick_o(tick)
  );

  ref_backlog_ctr #(.PEND_MAX(PEND_MAX)) u_backlog (
    .clk_i, .rst_ni,
    .inc_i(tick), .dec_i(pulse_done && (state_q == ST_RUN)), .clr_i(idle_hit),
    .pending_o(pend_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
      idle_q  <= '0;
      init_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      if (pulse_done) row_q <= row_q + 1'b1;
      // cycles since the last RAS start, only watched once initialized
      if (state_q != ST_RUN || start || idle_hit) idle_q <= '0;
      else                                        idle_q <= idle_q + 1'b1;
      unique case (state_q)
        ST_PAUSE: begin
          if (pause_q == PAUSE_W'(PAUSE_CYC - 1)) begin
            state_q <= ST_WAKE;
            wake_q  <= WAKE_W'(WAKE_CYCLES);
          end else begin
            pause_q <= pause_q + 1'b1;
          end
        end
        ST_WAKE: begin
          if (pulse_done) begin
            wake_q <= wake_q - 1'b1;
            if (wake_q == WAKE_W'(1)) begin
              state_q <= ST_RUN;
              init_q  <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (idle_hit) begin
            state_q <= ST_WAKE;
            wake_q  <= WAKE_W'(WAKE_CYCLES);
            init_q  <= 1'b0;
          end
        end
        default: state_q <= ST_PAUSE;
      endcase
    end
  end

  assign req_o       = req;
  assign busy_o      = active;
  assign init_done_o = init_q;
  assign ras_n_o     = ras_n;
  assign cas_n_o     = 1'b1;
  assign row_o       = row_q;

  assert_pause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (ras_n_o && !req_o));
  assert_init_after_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(pulse_done));
  assert_row_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_o));
  assert_grant_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(gnt_i && req_o));
  assert_busy_cover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> busy_o);
  assert_no_req_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);

endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int CLK_NS    = 4;
  localparam int ROW_W     = 8;
  localparam int ROWS      = 1 << ROW_W;
  localparam int PAUSE_CYC = 1000;   // 4000 ns
  localparam int LOW_CYC   = 38;     // ceil(150/4)
  localparam int PRE_CYC   = 25;     // 100/4
  localparam int INT_CYC   = 112;    // (131072/256 - 64)/4
  localparam int IDLE_CYC  = 32768;  // 131072/4
  localparam int WAKE_N    = 8;
  localparam int WD_LIMIT  = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0, gnt_i = 1'b0;
  logic req_o, busy_o, init_done_o, ras_n_o, cas_n_o;
  logic [ROW_W-1:0] row_o;

  dram_refresh_sched #(
    .CLK_NS(CLK_NS), .PAUSE_NS(4000), .REF_PERIOD_NS(131072),
    .ROW_W(ROW_W), .INT_MARGIN_NS(64)
  ) dut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int gnt_mode = 0;  // 0 off, 1 random, 2 on

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i)
    gnt_i <= (gnt_mode == 2) || (gnt_mode == 1 && ($urandom % 10) < 7);

  // port monitor
  int  cyc = 0, low_run = 0, high_run = 0;
  int  first_req = -1, wake_falls = 0, last_fall = -1, fall_gap = 0;
  int  falls = 0, tight = 0, seen_rows = 0;
  int  last_seen [ROWS];
  bit  prev_ras = 1'b1, prev_req = 1'b0, prev_init = 1'b0, any_fall = 1'b0, track = 1'b0;
  logic [ROW_W-1:0] prev_row = '0, exp_row = '0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(ras_n_o === 1'b1 && cas_n_o === 1'b1 && req_o === 1'b0 && busy_o === 1'b0
          && init_done_o === 1'b0 && row_o === '0, "R1 reset outputs",
          {ras_n_o, cas_n_o, req_o, busy_o, init_done_o}, 5'b11000);
    end else begin
      cyc++;
      if (cas_n_o !== 1'b1) chk(0, "R5 cas_n high", cas_n_o, 1);
      if (!ras_n_o && !busy_o) chk(0, "R7 busy while RAS low", busy_o, 1);
      if (busy_o && req_o) chk(0, "R7 no request while busy", req_o, 0);
      if (cyc < PAUSE_CYC && (req_o || !ras_n_o))
        chk(0, "R2 quiet pause", {req_o, ras_n_o}, 2'b01);
      if (req_o && first_req < 0) begin
        first_req = cyc;
        chk(cyc == PAUSE_CYC, "R2 first request edge", cyc, PAUSE_CYC);
      end
      if (!ras_n_o && prev_ras) begin
        chk(prev_req && gnt_i, "R7 start needs req and gnt", {prev_req, gnt_i}, 2'b11);
        if (any_fall) begin
          chk(row_o == exp_row, "R6 row step", row_o, exp_row);
          chk(high_run >= PRE_CYC, "R4 precharge width", high_run, PRE_CYC);
          if (high_run == PRE_CYC + 1) tight++;
          fall_gap = cyc - last_fall;
        end else begin
          chk(row_o == '0, "R6 first row", row_o, 0);
        end
        exp_row  = row_o + 1'b1;
        any_fall = 1'b1;
        last_fall = cyc;
        falls++;
        if (!init_done_o) wake_falls++;
        if (track) begin
          if (last_seen[row_o] < 0) seen_rows++;
          else chk(cyc - last_seen[row_o] <= IDLE_CYC, "R8 row revisit window",
                   cyc - last_seen[row_o], IDLE_CYC);
          last_seen[row_o] = cyc;
        end
        low_run = 1;
      end else if (!ras_n_o) begin
        low_run++;
        if (row_o != prev_row) chk(0, "R6 row stable while RAS low", row_o, prev_row);
      end
      if (ras_n_o && !prev_ras) begin
        chk(low_run == LOW_CYC, "R4 low width", low_run, LOW_CYC);
        high_run = 1;
      end else if (ras_n_o) begin
        high_run++;
      end
      if (init_done_o && !prev_init) begin
        chk(wake_falls == WAKE_N && ras_n_o && cyc > PAUSE_CYC, "R3 R10 wake count at init",
            wake_falls, WAKE_N);
        wake_falls = 0;
        track = 1'b1;
        seen_rows = 0;
        for (int i = 0; i < ROWS; i++) last_seen[i] = -1;
      end
      if (!init_done_o && prev_init) begin
        chk(cyc - last_fall == IDLE_CYC, "R10 idle drop timing", cyc - last_fall, IDLE_CYC);
        track = 1'b0;
        wake_falls = 0;
      end
    end
    prev_ras  = ras_n_o;
    prev_req  = req_o;
    prev_init = init_done_o;
    prev_row  = row_o;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk_i) begin
    wd++;
    if (wd == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", wd, WD_LIMIT);
      finish_run();
    end
  end

  task automatic wait_init(input bit level, input int limit);
    for (int i = 0; i < limit && init_done_o !== level; i++) @(negedge clk_i);
  endtask

  initial begin
    int f0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < ROWS; i++) last_seen[i] = -1;
    repeat (4) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    gnt_mode = 1;

    wait_init(1'b1, PAUSE_CYC + 2000);
    chk(init_done_o === 1'b1, "R3 init completes", init_done_o, 1);

    // random grant over more than a full refresh sweep
    repeat (36000) @(negedge clk_i);
    chk(seen_rows == ROWS, "R8 all rows in period", seen_rows, ROWS);

    // backlog: withhold grant across five slots, then release
    gnt_mode = 0;
    repeat (5 * INT_CYC + 20) @(negedge clk_i);
    chk(req_o === 1'b1, "R9 request held while no grant", req_o, 1);
    tight = 0;
    gnt_mode = 2;
    repeat (600) @(negedge clk_i);
    chk(tight >= 4, "R9 backlog back to back", tight, 4);

    // steady spacing with permanent grant
    repeat (2000) @(negedge clk_i);
    f0 = falls;
    for (int i = 0; i < 400 && falls == f0; i++) @(negedge clk_i);
    f0 = falls;
    for (int i = 0; i < 400 && falls == f0; i++) @(negedge clk_i);
    chk(fall_gap == INT_CYC, "R8 slot spacing", fall_gap, INT_CYC);

    // starve the memory for a full period
    gnt_mode = 0;
    wait_init(1'b0, IDLE_CYC + 500);
    chk(init_done_o === 1'b0, "R10 init drops after idle", init_done_o, 0);
    repeat (50) @(negedge clk_i);
    chk(init_done_o === 1'b0 && req_o === 1'b1, "R10 wake request pending",
        {init_done_o, req_o}, 2'b01);
    gnt_mode = 1;
    wait_init(1'b1, 2000);
    chk(init_done_o === 1'b1, "R10 reinit completes", init_done_o, 1);

    repeat (1000) @(negedge clk_i);
    finish_run();
  end

endmodule